// File: doc/BRIEF.md
# Automatic Blink and Fade Sequencer

This block drives the timing side of a multi-colour LED controller. Colour channels are organised in groups of three. Each group has its own timebase, which splits a repeating pattern period into 64 steps. Each colour channel has a programmable switch-on step and switch-off step inside that period. The block produces two outputs per channel: a gate that says whether the channel is lit, and a 6-bit brightness duty. The duty can ramp up after switch-on and ramp down before switch-off, with separately selectable ramp lengths for each group. A downstream current source or PWM stage turns the duty into light; that stage is outside this block.

The timebase advances on a slow enable pulse (`tick`), nominally 500 kHz. A 3-bit period code selects the step length as 2^(BASE_SHIFT+code) ticks. With the default BASE_SHIFT of 11, codes 0 to 5 give periods of about 0.262, 0.524, 1.049, 2.097, 4.194 and 8.389 s. BASE_SHIFT must be at least 6.

A group can repeat its pattern forever or run it once and then go dark. A follow control lets every group after the first take the first group's timebase, enable, one-shot setting and ramp codes, so that the groups blink in lockstep while keeping their own on and off steps.

Top module: `led_seq_core`

## Requirements
- R1: While `rst_n` is low, every `gate_o` bit and every `duty_o` field is 0.
- R2: A running group steps through positions 0 to 63. Each step lasts 2^(BASE_SHIFT+c) ticks, where c is the group's period code, and position 63 wraps to 0. Period codes 6 and 7 keep the group idle: counters stay at 0 and the group's outputs stay 0.
- R3: Channel k is lit at step s when on<off and on<=s<off, or when on>off and (s>=on or s<off). When on==off, the channel stays dark for the whole period.
- R4: The fine position is step*64 + floor(t/2^(BASE_SHIFT+c-6)), where t is the count of ticks into the current step. While lit with a non-zero fade-in code, the duty is limited to floor(e/L), where e = (fine - on*64) mod 4096 and L is the ramp length in steps.
- R5: While lit with a non-zero fade-out code, the duty is limited to floor(r/L), where r = (off*64 - fine) mod 4096.
- R6: The duty is the smaller of the two limits, capped at 63. A fade code of 0 imposes no limit, so a lit channel with both codes at 0 shows duty 63. A dark channel shows duty 0.
- R7: Fade codes 1 to 7 select ramp lengths of 1, 2, 4, 8, 16, 24 and 32 steps. 32 steps is half the period.
- R8: With one-shot set, a group runs a single period (64 steps) and then stays dark with its counters at 0 until its enable goes low.
- R9: With `follow_first` high, every group after group 0 uses group 0's timebase, enable, one-shot setting and fade codes. Its channels keep their own on and off steps.
- R10: The counters advance only in cycles where `tick` is high.
- R11: When a group's enable is low, its counters and any one-shot completion are cleared, and its channels are dark in the next cycle.
- R12: The outputs are registered. In the first cycle after a group starts, they show fine position 0 of step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase advance enable |
| grp_en | input | NGRP | Per-group automatic run enable |
| one_shot | input | NGRP | Per-group single-period mode |
| follow_first | input | 1 | Later groups follow group 0 |
| period_code | input | NGRP x 3 | Per-group period select |
| fade_in_code | input | NGRP x 3 | Per-group ramp-up length code |
| fade_out_code | input | NGRP x 3 | Per-group ramp-down length code |
| on_step | input | NCH x 6 | Per-channel switch-on step |
| off_step | input | NCH x 6 | Per-channel switch-off step |
| gate_o | output | NCH | Per-channel lit flag |
| duty_o | output | NCH x 6 | Per-channel brightness duty |

## Verification
The bench runs a cycle-by-cycle reference model and compares both outputs every cycle against it. The window rule is tried with three channel layouts: an ordinary window, one that wraps through step 63, and one with equal on and off steps. Together these separate the compare direction and the wrap handling. All seven ramp codes are exercised across overlapping windows. The 24-step case checks that the non-power-of-two division rounds exactly, and mixing fade-in and fade-out codes checks that the smaller limit wins. A half-rate irregular tick with longer period codes shows whether the step length and the sub-step position follow the code. Separate runs cover one-shot termination followed by a restart, invalid period codes, and a follower group whose own settings are invalid, which shows that the follower ignores them.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;
  localparam int STEP_W = 6;
  localparam int NSTEP = 1 << STEP_W;
  localparam int FINE_W = 2 * STEP_W;
  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] LAST_VALID_CODE = 3'd5;
  localparam int DIV3_MUL = 683;
  localparam int DIV3_SHIFT = 11;

  typedef logic [STEP_W-1:0] step_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [FINE_W-1:0] fine_t;
endpackage

// File: rtl/led_seq_timebase.sv
module led_seq_timebase
  import led_seq_pkg::*;
#(
  parameter int BASE_SHIFT = 11
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  enable,
  input  logic  one_shot,
  input  code_t per_code,
  output logic  active,
  output step_t step,
  output step_t sub,
  output logic  done
);
  localparam int PRE_W = BASE_SHIFT + int'(LAST_VALID_CODE) + 1;
  localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);

  logic [PRE_W-1:0] pre_q, pre_d, len_m1;
  step_t step_q, step_d;
  logic done_q, done_d;
  logic run, step_end, adv_en;
  int sh_len, sh_sub;

  always_comb begin
    run      = enable && (per_code <= LAST_VALID_CODE);
    sh_len   = BASE_SHIFT + int'(per_code);
    sh_sub   = BASE_SHIFT - STEP_W + int'(per_code);
    len_m1   = (PRE_ONE << sh_len) - PRE_ONE;
    step_end = (pre_q == len_m1);
    adv_en   = run && !done_q && tick;
  end

  always_comb begin
    pre_d  = pre_q;
    step_d = step_q;
    done_d = done_q;
    if (!run) begin
      pre_d  = '0;
      step_d = '0;
      done_d = 1'b0;
    end else if (adv_en) begin
      if (step_end) begin
        pre_d = '0;
        if (step_q == step_t'(NSTEP - 1)) begin
          step_d = '0;
          done_d = one_shot;
        end else begin
          step_d = step_q + 1'b1;
        end
      end else begin
        pre_d = pre_q + PRE_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      step_q <= step_d;
      done_q <= done_d;
    end
  end

  assign active = run && !done_q;
  assign step   = step_q;
  assign sub    = step_t'(pre_q >> sh_sub);
  assign done   = done_q;
endmodule

// File: rtl/led_seq_ramp.sv
module led_seq_ramp
  import led_seq_pkg::*;
(
  input  fine_t x,
  input  code_t code,
  output step_t level
);
  localparam int PROD_W = FINE_W - 3 + 10;

  fine_t q;
  logic [PROD_W-1:0] prod;

  always_comb begin
    prod = '0;
    q    = fine_t'(NSTEP - 1);
    case (code)
      3'd1: q = x;
      3'd2: q = x >> 1;
      3'd3: q = x >> 2;
      3'd4: q = x >> 3;
      3'd5: q = x >> 4;
      3'd6: begin
        prod = PROD_W'(x[FINE_W-1:3]) * PROD_W'(DIV3_MUL);
        q    = fine_t'(prod >> DIV3_SHIFT);
      end
      3'd7: q = x >> 5;
      default: q = fine_t'(NSTEP - 1);
    endcase
    level = (q > fine_t'(NSTEP - 1)) ? step_t'(NSTEP - 1) : q[STEP_W-1:0];
  end
endmodule

// File: rtl/led_seq_channel.sv
module led_seq_channel
  import led_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  active,
  input  step_t step,
  input  step_t sub,
  input  step_t on_pos,
  input  step_t off_pos,
  input  code_t fin_code,
  input  code_t fout_code,
  output logic  gate_q,
  output step_t duty_q
);
  logic in_win, gate_d;
  fine_t fine, since_on, until_off;
  step_t lvl_in, lvl_out, duty_d;

  always_comb begin
    if (on_pos < off_pos)      in_win = (step >= on_pos) && (step < off_pos);
    else if (on_pos > off_pos) in_win = (step >= on_pos) || (step < off_pos);
    else                       in_win = 1'b0;
    fine      = {step, sub};
    since_on  = fine - {on_pos, {STEP_W{1'b0}}};
    until_off = {off_pos, {STEP_W{1'b0}}} - fine;
  end

  led_seq_ramp u_up (.x(since_on),  .code(fin_code),  .level(lvl_in));
  led_seq_ramp u_dn (.x(until_off), .code(fout_code), .level(lvl_out));

  always_comb begin
    gate_d = active && in_win;
    duty_d = '0;
    if (gate_d) duty_d = (lvl_in < lvl_out) ? lvl_in : lvl_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      duty_q <= '0;
    end else begin
      gate_q <= gate_d;
      duty_q <= duty_d;
    end
  end
endmodule

// File: rtl/led_seq_core.sv
module led_seq_core
  import led_seq_pkg::*;
#(
  parameter int NGRP       = 2,
  parameter int NCOL       = 3,
  parameter int BASE_SHIFT = 11
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   tick,
  input  logic [NGRP-1:0]                        grp_en,
  input  logic [NGRP-1:0]                        one_shot,
  input  logic                                   follow_first,
  input  logic [NGRP-1:0][CODE_W-1:0]            period_code,
  input  logic [NGRP-1:0][CODE_W-1:0]            fade_in_code,
  input  logic [NGRP-1:0][CODE_W-1:0]            fade_out_code,
  input  logic [NGRP*NCOL-1:0][STEP_W-1:0]       on_step,
  input  logic [NGRP*NCOL-1:0][STEP_W-1:0]       off_step,
  output logic [NGRP*NCOL-1:0]                   gate_o,
  output logic [NGRP*NCOL-1:0][STEP_W-1:0]       duty_o
);
  localparam int NCH = NGRP * NCOL;

  logic  [NGRP-1:0] tb_active, tb_done;
  step_t            tb_step [NGRP];
  step_t            tb_sub  [NGRP];
  logic  [NGRP-1:0] eff_active;
  step_t            eff_step [NGRP];
  step_t            eff_sub  [NGRP];
  code_t            eff_fin  [NGRP];
  code_t            eff_fout [NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    led_seq_timebase #(.BASE_SHIFT(BASE_SHIFT)) u_tb (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .enable   (grp_en[g]),
      .one_shot (one_shot[g]),
      .per_code (period_code[g]),
      .active   (tb_active[g]),
      .step     (tb_step[g]),
      .sub      (tb_sub[g]),
      .done     (tb_done[g])
    );
    if (g == 0) begin : g_lead
      assign eff_active[g] = tb_active[g];
      assign eff_step[g]   = tb_step[g];
      assign eff_sub[g]    = tb_sub[g];
      assign eff_fin[g]    = fade_in_code[g];
      assign eff_fout[g]   = fade_out_code[g];
    end else begin : g_follow
      assign eff_active[g] = follow_first ? tb_active[0]     : tb_active[g];
      assign eff_step[g]   = follow_first ? tb_step[0]       : tb_step[g];
      assign eff_sub[g]    = follow_first ? tb_sub[0]        : tb_sub[g];
      assign eff_fin[g]    = follow_first ? fade_in_code[0]  : fade_in_code[g];
      assign eff_fout[g]   = follow_first ? fade_out_code[0] : fade_out_code[g];
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int GI = ch / NCOL;
    led_seq_channel u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (eff_active[GI]),
      .step      (eff_step[GI]),
      .sub       (eff_sub[GI]),
      .on_pos    (on_step[ch]),
      .off_pos   (off_step[ch]),
      .fin_code  (eff_fin[GI]),
      .fout_code (eff_fout[GI]),
      .gate_q    (gate_o[ch]),
      .duty_q    (duty_o[ch])
    );
  end
endmodule

// File: rtl/led_seq_chk.sv
module led_seq_chk
  import led_seq_pkg::*;
#(
  parameter int NGRP = 2,
  parameter int NCOL = 3
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             tick,
  input logic [NGRP-1:0]                  grp_en,
  input logic [NGRP-1:0][CODE_W-1:0]      period_code,
  input logic [NGRP-1:0][CODE_W-1:0]      fade_in_code,
  input logic [NGRP-1:0][CODE_W-1:0]      fade_out_code,
  input logic [NGRP*NCOL-1:0][STEP_W-1:0] on_step,
  input logic [NGRP*NCOL-1:0][STEP_W-1:0] off_step,
  input logic [NGRP*NCOL-1:0]             gate_o,
  input logic [NGRP*NCOL-1:0][STEP_W-1:0] duty_o,
  input logic [NGRP-1:0]                  tb_active,
  input logic [NGRP-1:0]                  tb_done,
  input step_t                            tb_step [NGRP]
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (gate_o == '0 && duty_o == '0)
        else $error("R1 outputs not quiet in reset");
    end
  end

  a_r2_invalid_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (period_code[0] > LAST_VALID_CODE) |=> (gate_o[NCOL-1:0] == '0));

  a_r3_equal_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (on_step[0] == off_step[0]) |=> !gate_o[0]);

  a_r6_flat_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (fade_in_code[0] == 3'd0 && fade_out_code[0] == 3'd0)
      |=> (!gate_o[0] || duty_o[0] == step_t'(NSTEP - 1)));

  a_r8_oneshot_dark: assert property (@(posedge clk) disable iff (!rst_n)
    tb_done[0] |=> (gate_o[NCOL-1:0] == '0));

  a_r10_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_active[0] && !tick) |=> $stable(tb_step[0]));

  a_r11_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_en[0] |=> (gate_o[NCOL-1:0] == '0 && tb_step[0] == '0));
endmodule

bind led_seq_core led_seq_chk #(.NGRP(NGRP), .NCOL(NCOL)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick          (tick),
  .grp_en        (grp_en),
  .period_code   (period_code),
  .fade_in_code  (fade_in_code),
  .fade_out_code (fade_out_code),
  .on_step       (on_step),
  .off_step      (off_step),
  .gate_o        (gate_o),
  .duty_o        (duty_o),
  .tb_active     (tb_active),
  .tb_done       (tb_done),
  .tb_step       (tb_step)
);

// File: tb/tb_led_seq_core.sv
module tb_led_seq_core;
  localparam int NGRP = 2;
  localparam int NCOL = 3;
  localparam int NCH  = NGRP * NCOL;
  localparam int BS   = 6;

  typedef struct packed {
    logic [NCH-1:0]      g;
    logic [NCH-1:0][5:0] d;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n, tick, follow_first;
  logic [NGRP-1:0] grp_en, one_shot;
  logic [NGRP-1:0][2:0] period_code, fade_in_code, fade_out_code;
  logic [NCH-1:0][5:0] on_step, off_step;
  logic [NCH-1:0] gate_o;
  logic [NCH-1:0][5:0] duty_o;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  exp_t sb_q[$];
  int n_ref [NGRP];
  bit done_ref [NGRP];
  bit tick_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit finished = 1'b0;

  led_seq_core #(.NGRP(NGRP), .NCOL(NCOL), .BASE_SHIFT(BS)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .grp_en(grp_en), .one_shot(one_shot),
    .follow_first(follow_first), .period_code(period_code),
    .fade_in_code(fade_in_code), .fade_out_code(fade_out_code),
    .on_step(on_step), .off_step(off_step), .gate_o(gate_o), .duty_o(duty_o)
  );

  always #5 clk = ~clk;

  // R7: ramp length in steps for each fade code
  function automatic int ramp_len(input logic [2:0] c);
    case (c)
      3'd1: return 1;  3'd2: return 2;  3'd3: return 4;  3'd4: return 8;
      3'd5: return 16; 3'd6: return 24; 3'd7: return 32;
      default: return 0;
    endcase
  endfunction

  function automatic int limit(input int x, input logic [2:0] c);
    int q;
    if (c == 3'd0) return 63;
    q = x / ramp_len(c);
    return (q > 63) ? 63 : q;
  endfunction

  // reference model: expectation for the output after this edge, then advance
  always @(posedge clk) begin
    if (rst_n) begin
      exp_t e;
      bit run_g [NGRP];
      for (int g = 0; g < NGRP; g++)
        run_g[g] = grp_en[g] && (period_code[g] <= 3'd5) && !done_ref[g];
      for (int ch = 0; ch < NCH; ch++) begin
        int g, src, len, stp, sub, fine, on, off, ein, rout, a, b;
        bit lit;
        g   = ch / NCOL;
        src = (g > 0 && follow_first) ? 0 : g;
        e.g[ch] = 1'b0;
        e.d[ch] = 6'd0;
        if (run_g[src]) begin
          len  = 1 << (BS + int'(period_code[src]));
          stp  = n_ref[src] / len;
          sub  = (n_ref[src] % len) / (len / 64);
          fine = stp * 64 + sub;
          on   = int'(on_step[ch]);
          off  = int'(off_step[ch]);
          if (on < off)      lit = (stp >= on) && (stp < off);
          else if (on > off) lit = (stp >= on) || (stp < off);
          else               lit = 1'b0;
          if (lit) begin
            ein  = (fine - on * 64 + 4096) % 4096;
            rout = (off * 64 - fine + 4096) % 4096;
            a = limit(ein, fade_in_code[src]);
            b = limit(rout, fade_out_code[src]);
            e.g[ch] = 1'b1;
            e.d[ch] = 6'((a < b) ? a : b);
          end
        end
      end
      sb_q.push_back(e);
      for (int g = 0; g < NGRP; g++) begin
        if (!(grp_en[g] && period_code[g] <= 3'd5)) begin
          n_ref[g] = 0;
          done_ref[g] = 1'b0;
        end else if (!done_ref[g] && tick) begin
          n_ref[g]++;
          if (n_ref[g] == 64 * (1 << (BS + int'(period_code[g])))) begin
            n_ref[g] = 0;
            done_ref[g] = one_shot[g];
          end
        end
      end
    end
  end

  // monitor: pop and compare
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_cmp++;
      if (gate_o !== e.g || duty_o !== e.d) begin
        n_bad++;
        $display("FAIL %s t=%0t gate act=%b exp=%b duty act=%h exp=%h",
                 cur_req, $time, gate_o, e.g, duty_o, e.d);
      end
    end
  end

  // tick driver
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tick <= tick_mode ? lfsr[0] : 1'b1;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_idle();
    grp_en = '0;
    one_shot = '0;
    follow_first = 1'b0;
    wait_cyc(3);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(190000 * 10);
    n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    summary();
  end

  initial begin
    rst_n = 1'b0; tick = 1'b1; grp_en = '0; one_shot = '0; follow_first = 1'b0;
    period_code = '0; fade_in_code = '0; fade_out_code = '0;
    on_step = '0; off_step = '0;
    for (int g = 0; g < NGRP; g++) begin n_ref[g] = 0; done_ref[g] = 1'b0; end
    wait_cyc(3);
    n_cmp++;
    if (gate_o !== '0 || duty_o !== '0) begin
      n_bad++;
      $display("FAIL R1 reset act=%b/%h exp=0/0", gate_o, duty_o);
    end
    rst_n = 1'b1;
    wait_cyc(2);

    // windows: plain, wrapping, equal; flat duty; start at step 0
    cur_req = "R3/R6/R12";
    on_step[0] = 6'd0;  off_step[0] = 6'd5;
    on_step[1] = 6'd50; off_step[1] = 6'd6;
    on_step[2] = 6'd33; off_step[2] = 6'd33;
    grp_en[0] = 1'b1;
    wait_cyc(4096 + 300);
    go_idle();

    // ramps with every code, both groups independent
    cur_req = "R4/R5/R7";
    fade_in_code[0] = 3'd3; fade_out_code[0] = 3'd6;
    on_step[0] = 6'd2;  off_step[0] = 6'd40;
    on_step[1] = 6'd10; off_step[1] = 6'd60;
    on_step[2] = 6'd60; off_step[2] = 6'd30;
    fade_in_code[1] = 3'd4; fade_out_code[1] = 3'd5;
    on_step[3] = 6'd0;  off_step[3] = 6'd32;
    on_step[4] = 6'd20; off_step[4] = 6'd21;
    on_step[5] = 6'd63; off_step[5] = 6'd0;
    grp_en = 2'b11;
    wait_cyc(4096 + 300);
    go_idle();
    fade_in_code[0] = 3'd7; fade_out_code[0] = 3'd1;
    fade_in_code[1] = 3'd2; fade_out_code[1] = 3'd6;
    grp_en = 2'b11;
    wait_cyc(4096 + 300);
    go_idle();

    // irregular tick, longer periods
    cur_req = "R10/R2";
    tick_mode = 1'b1;
    period_code[0] = 3'd1; period_code[1] = 3'd2;
    fade_in_code[0] = 3'd5; fade_out_code[0] = 3'd2;
    grp_en = 2'b11;
    wait_cyc(17000);
    go_idle();
    tick_mode = 1'b0;

    // invalid period codes
    cur_req = "R2 invalid";
    period_code[0] = 3'd6; period_code[1] = 3'd7;
    grp_en = 2'b11;
    wait_cyc(300);
    go_idle();

    // single run, then disable and restart
    cur_req = "R8/R11";
    period_code = '0;
    fade_in_code[0] = 3'd0; fade_out_code[0] = 3'd0;
    on_step[0] = 6'd60; off_step[0] = 6'd3;
    one_shot[0] = 1'b1;
    grp_en[0] = 1'b1;
    wait_cyc(4096 + 500);
    grp_en[0] = 1'b0;
    wait_cyc(3);
    grp_en[0] = 1'b1;
    wait_cyc(500);
    go_idle();

    // follower group with its own settings invalid
    cur_req = "R9";
    fade_in_code[0] = 3'd3; fade_out_code[0] = 3'd4;
    period_code[1] = 3'd7; fade_in_code[1] = 3'd0; fade_out_code[1] = 3'd0;
    on_step[3] = 6'd5;  off_step[3] = 6'd45;
    on_step[4] = 6'd40; off_step[4] = 6'd10;
    on_step[5] = 6'd0;  off_step[5] = 6'd63;
    follow_first = 1'b1;
    grp_en = 2'b01;
    wait_cyc(4096 + 300);
    go_idle();

    wait_cyc(3);
    summary();
  end
endmodule